// File: doc/BRIEF.md
# Burst-of-Two Separate-Port SRAM Core

This block is a synthesizable behavioural model of a pipelined synchronous SRAM. It has a dedicated read data output and a dedicated write data input. Both share one command bus made of a load strobe, a read/write select and a burst address. Every access moves a burst of two words. The model runs on one double-rate clock `clk`. An internal phase bit marks each rising edge of `clk` as either a positive edge, where commands are taken, or a negative edge, which is the mid-cycle data edge. Write words enter on the positive and negative edges of the cycle after the command, and each word has its own active-low byte-lane selects. Read words leave 1.5 cycles after the command.

Writes are posted. A write's address, both words and both lane masks are kept in a holding entry. They are copied into the array at the first data edge of the next write, so an array write never competes with a read. A read whose burst address matches the held entry takes each enabled lane from the held entry and every other lane from the array.

The write sequencer has states WP_IDLE, WP_ARMED, WP_BEAT0, WP_BEAT1 and WP_BEAT1_ARMED:
- A write command taken in WP_IDLE moves it to WP_ARMED.
- WP_ARMED always moves to WP_BEAT0, where word 0 is captured and the previous held write is committed.
- WP_BEAT0 moves to WP_BEAT1_ARMED if a new write is commanded on that edge, and to WP_BEAT1 if not. Word 1 is captured in both of those states.
- WP_BEAT1 returns to WP_IDLE.
- WP_BEAT1_ARMED returns to WP_BEAT0.

The read sequencer has states RP_IDLE, RP_LEAD, RP_GAP, RP_FIRST and RP_SECOND:
- A read command taken in RP_IDLE moves it to RP_LEAD.
- RP_LEAD always moves to RP_GAP. A read taken in RP_GAP is queued.
- RP_GAP always moves to RP_FIRST, where word 0 is presented.
- RP_FIRST always moves to RP_SECOND, where word 1 is presented.
- RP_SECOND moves to RP_FIRST if a read is queued. Otherwise it moves to RP_LEAD on a new read, or to RP_IDLE.

Top module: `bst2_sio_sram`

## Requirements
- R1: While `rst_n` is low and after it is released, `rd_oe` is low and `rd_data` is zero, both sequencers are idle and any held write is discarded. The first `clk` edge after release is a positive edge, and positive and negative edges then alternate.
- R2: Commands are decoded only on positive edges. `ld_n` low with `rw` high starts a read, `ld_n` low with `rw` low starts a write, and `ld_n` high does nothing. On negative edges `ld_n`, `rw` and `addr` are ignored.
- R3: `addr` names a two-word burst. Word 0 is stored at word index {addr,0} and word 1 at {addr,1}, and both a write and a read transfer word 0 first.
- R4: For a write commanded on edge e, word 0 and its lane selects are sampled on edge e+2 (positive) and word 1 and its lane selects on edge e+3 (negative).
- R5: `bws_n[i]` low enables lane i, which is bits [9i+8:9i] of the word. The selects are sampled with each word and may differ between the two words. A disabled lane keeps its stored contents.
- R6: For a read commanded on edge e, `rd_oe` goes high and word 0 appears on `rd_data` after edge e+3, and word 1 appears after edge e+4.
- R7: Whenever no read word is being presented, `rd_oe` is low and `rd_data` is all zeros. After word 1 of a burst with no read following it, `rd_oe` falls on the next edge.
- R8: A read commanded on every positive edge gives an unbroken stream of words. A write commanded on every positive edge is accepted without losing data.
- R9: A write stays in the holding entry until the first data edge of the next write, which copies its enabled lanes into the array.
- R10: A read whose address equals the held write returns, for each word, the held lanes whose selects were enabled and the array contents for the other lanes.
- R11: A read returns the data of all writes commanded before it, and no data from writes commanded after it, including a write to the same address in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; its edges alternate between positive and negative phases |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Active-low load strobe, taken on positive edges |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Burst address |
| wd | input | LANES*LANE_W | Write data word |
| bws_n | input | LANES | Active-low byte-lane write selects for the current word |
| rd_data | output | LANES*LANE_W | Read data word, zero when idle |
| rd_oe | output | 1 | High while a read word is presented |

## Verification
Counting the command edge as edge 0:
- Write word 0 is taken on edge 2 and word 1 on edge 3.
- Read word 0 is visible after edge 3 and word 1 after edge 4.
- `rd_oe` falls after edge 5 unless another read follows.

The bench drives inputs and samples outputs on the falling edge of `clk`, so every sample falls between two active edges. A command issued in cycle c has word 1 checked right after the positive edge of cycle c+2, and word 0 right after the negative edge of cycle c+1. On every other half cycle the bench expects the idle output. The expected words come from a reference array that applies each write when it is issued, so a read sees exactly the writes that came before it.

// File: rtl/bst2_pkg.sv
package bst2_pkg;
    localparam int BEATS = 2;

    typedef enum logic [2:0] {
        WP_IDLE,
        WP_ARMED,
        WP_BEAT0,
        WP_BEAT1,
        WP_BEAT1_ARMED
    } wr_state_e;

    typedef enum logic [2:0] {
        RP_IDLE,
        RP_LEAD,
        RP_GAP,
        RP_FIRST,
        RP_SECOND
    } rd_state_e;
endpackage

// File: rtl/bst2_store.sv
module bst2_store
    import bst2_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int WORD_W = LANE_W * LANES,
    localparam int WORDS  = BEATS << ADDR_W
) (
    input  logic                               clk,
    input  logic                               we,
    input  logic [ADDR_W-1:0]                  waddr,
    input  logic [BEATS-1:0][WORD_W-1:0]       wdata,
    input  logic [BEATS-1:0][LANES-1:0]        wmask,
    input  logic [ADDR_W-1:0]                  raddr,
    input  logic                               rbeat,
    output logic [WORD_W-1:0]                  rword
);
    logic [WORD_W-1:0] mem [WORDS];

    // Lane-granular commit of both words of a held burst.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < BEATS; b++) begin
                for (int l = 0; l < LANES; l++) begin
                    if (wmask[b][l])
                        mem[{waddr, 1'(b)}][l*LANE_W +: LANE_W] <= wdata[b][l*LANE_W +: LANE_W];
                end
            end
        end
    end

    assign rword = mem[{raddr, rbeat}];
endmodule

// File: rtl/bst2_wr_port.sv
module bst2_wr_port
    import bst2_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pos_edge,
    input  logic                         cmd_wr,
    input  logic [ADDR_W-1:0]            cmd_addr,
    input  logic [WORD_W-1:0]            wd,
    input  logic [LANES-1:0]             bws_n,
    output logic                         pend_valid,
    output logic [ADDR_W-1:0]            pend_addr,
    output logic [BEATS-1:0][WORD_W-1:0] pend_data,
    output logic [BEATS-1:0][LANES-1:0]  pend_mask,
    output logic                         commit_en
);
    wr_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_hold;
    logic              take, accept, cap_first, cap_second;

    assign take = pos_edge && cmd_wr;

    always_comb begin
        unique case (state_q)
            WP_IDLE:        state_d = take ? WP_ARMED : WP_IDLE;
            WP_ARMED:       state_d = WP_BEAT0;
            WP_BEAT0:       state_d = take ? WP_BEAT1_ARMED : WP_BEAT1;
            WP_BEAT1:       state_d = WP_IDLE;
            WP_BEAT1_ARMED: state_d = WP_BEAT0;
            default:        state_d = WP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        accept     = take && (state_q == WP_IDLE || state_q == WP_BEAT0);
        cap_first  = (state_q == WP_BEAT0);
        cap_second = (state_q == WP_BEAT1 || state_q == WP_BEAT1_ARMED);
        commit_en  = cap_first && pend_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_hold  <= '0;
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_data  <= '0;
            pend_mask  <= '0;
        end else begin
            if (accept)
                addr_hold <= cmd_addr;
            if (cap_first) begin
                pend_valid   <= 1'b1;
                pend_addr    <= addr_hold;
                pend_data[0] <= wd;
                pend_mask[0] <= ~bws_n;
                pend_mask[1] <= '0;
            end
            if (cap_second) begin
                pend_data[1] <= wd;
                pend_mask[1] <= ~bws_n;
            end
        end
    end
endmodule

// File: rtl/bst2_rd_port.sv
module bst2_rd_port
    import bst2_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pos_edge,
    input  logic              cmd_rd,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              fire,
    output logic              beat,
    output logic [ADDR_W-1:0] cur_addr
);
    rd_state_e         state_q, state_d;
    logic              queued_q, take;
    logic [ADDR_W-1:0] next_addr;

    assign take = pos_edge && cmd_rd;

    always_comb begin
        unique case (state_q)
            RP_IDLE:   state_d = take ? RP_LEAD : RP_IDLE;
            RP_LEAD:   state_d = RP_GAP;
            RP_GAP:    state_d = RP_FIRST;
            RP_FIRST:  state_d = RP_SECOND;
            RP_SECOND: state_d = queued_q ? RP_FIRST : (take ? RP_LEAD : RP_IDLE);
            default:   state_d = RP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        fire = (state_q == RP_FIRST) || (state_q == RP_SECOND);
        beat = (state_q == RP_SECOND);
    end

    // Address bookkeeping: one burst in flight, at most one queued behind it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            queued_q  <= 1'b0;
            cur_addr  <= '0;
            next_addr <= '0;
        end else begin
            unique case (state_q)
                RP_IDLE: if (take) cur_addr <= cmd_addr;
                RP_GAP: begin
                    queued_q <= take;
                    if (take) next_addr <= cmd_addr;
                end
                RP_SECOND: begin
                    queued_q <= queued_q && take;
                    if (queued_q) begin
                        cur_addr <= next_addr;
                        if (take) next_addr <= cmd_addr;
                    end else if (take) begin
                        cur_addr <= cmd_addr;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bst2_sio_sram.sv
module bst2_sio_sram
    import bst2_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wd,
    input  logic [LANES-1:0]  bws_n,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_oe
);
    logic                         phase_q, pos_edge;
    logic                         pend_valid, commit_en, fire, beat, hit;
    logic [ADDR_W-1:0]            pend_addr, cur_addr;
    logic [BEATS-1:0][WORD_W-1:0] pend_data;
    logic [BEATS-1:0][LANES-1:0]  pend_mask;
    logic [WORD_W-1:0]            arr_word, fwd_word;

    // phase_q = 0: the coming edge is a positive (command) edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end
    assign pos_edge = ~phase_q;

    bst2_wr_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_wr (
        .clk, .rst_n, .pos_edge,
        .cmd_wr(!ld_n && !rw), .cmd_addr(addr), .wd, .bws_n,
        .pend_valid, .pend_addr, .pend_data, .pend_mask, .commit_en
    );

    bst2_rd_port #(.ADDR_W(ADDR_W)) u_rd (
        .clk, .rst_n, .pos_edge,
        .cmd_rd(!ld_n && rw), .cmd_addr(addr),
        .fire, .beat, .cur_addr
    );

    bst2_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_store (
        .clk, .we(commit_en), .waddr(pend_addr), .wdata(pend_data), .wmask(pend_mask),
        .raddr(cur_addr), .rbeat(beat), .rword(arr_word)
    );

    assign hit = pend_valid && (pend_addr == cur_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign fwd_word[l*LANE_W +: LANE_W] = (hit && pend_mask[beat][l])
            ? pend_data[beat][l*LANE_W +: LANE_W]
            : arr_word[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_oe   <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_oe   <= fire;
            rd_data <= fire ? fwd_word : '0;
        end
    end
endmodule

// File: rtl/bst2_sio_sram_chk.sv
module bst2_sio_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic ld_n,
    input logic rw,
    input logic rd_oe,
    input logic pos_edge,
    input logic pend_valid,
    input logic commit_en
);
    // R3: output bursts always span two edges
    assert_burst_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_oe) |=> rd_oe);

    // R6: read command on a positive edge yields words after edges +3 and +4
    assert_read_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_edge && !ld_n && rw) |-> ##4 rd_oe ##1 rd_oe);

    // R6: word 0 is launched by a negative edge
    assert_oe_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_oe) |-> pos_edge);

    // R9: a write is held after its first data edge
    assert_post_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_edge && !ld_n && !rw) |-> ##3 pend_valid);

    // R9: array commits happen only on positive edges
    assert_commit_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> pos_edge);
endmodule

bind bst2_sio_sram bst2_sio_sram_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .rd_oe(rd_oe),
    .pos_edge(pos_edge), .pend_valid(pend_valid), .commit_en(commit_en)
);

// File: tb/bst2_sio_sram_test.sv
module bst2_sio_sram_test;
    localparam int AW = 8;
    localparam int WW = 18;
    localparam int NOPS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_n = 1'b1;
    logic          rw = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [WW-1:0] wd = '0;
    logic [1:0]    bws_n = 2'b11;
    logic [WW-1:0] rd_data;
    logic          rd_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bst2_sio_sram uut (.clk, .rst_n, .ld_n, .rw, .addr, .wd, .bws_n, .rd_data, .rd_oe);

    // Fields: [49:48] kind (0 nop, 1 read, 2 write), [47:40] addr,
    // [39:22] word0, [21:4] word1, [3:2] word0 bws_n, [1:0] word1 bws_n
    localparam logic [49:0] OPS [NOPS] = '{
        {2'd2, 8'h10, 18'h12345, 18'h2ABCD, 2'b00, 2'b00}, // R4 full write
        {2'd2, 8'h11, 18'h00111, 18'h00222, 2'b00, 2'b00}, // R8 write every cycle
        {2'd1, 8'h10, 18'h0,     18'h0,     2'b11, 2'b11}, // R9 committed data
        {2'd1, 8'h11, 18'h0,     18'h0,     2'b11, 2'b11}, // R10 full forward
        {2'd2, 8'h11, 18'h3FFFF, 18'h15555, 2'b10, 2'b01}, // R5 per-word lanes
        {2'd1, 8'h11, 18'h0,     18'h0,     2'b11, 2'b11}, // R10 merged forward
        {2'd0, 8'h00, 18'h0,     18'h0,     2'b11, 2'b11},
        {2'd2, 8'h12, 18'h0AAAA, 18'h05555, 2'b00, 2'b00},
        {2'd1, 8'h11, 18'h0,     18'h0,     2'b11, 2'b11}, // R9 R5 masked commit
        {2'd2, 8'h12, 18'h3F00F, 18'h2F0F0, 2'b11, 2'b11}, // R5 no lanes
        {2'd1, 8'h12, 18'h0,     18'h0,     2'b11, 2'b11}, // R5 unchanged
        {2'd1, 8'h11, 18'h0,     18'h0,     2'b11, 2'b11}, // R8 back-to-back
        {2'd1, 8'h10, 18'h0,     18'h0,     2'b11, 2'b11}, // R11 before write
        {2'd2, 8'h10, 18'h1F0F0, 18'h30303, 2'b00, 2'b00}, // R11 later write
        {2'd1, 8'h10, 18'h0,     18'h0,     2'b11, 2'b11}, // R10 R3 forward
        {2'd0, 8'h00, 18'h0,     18'h0,     2'b11, 2'b11}
    };

    logic [WW-1:0] refm [512];
    logic          exp_v [NOPS];
    logic [WW-1:0] exp0 [NOPS];
    logic [WW-1:0] exp1 [NOPS];

    task automatic slot(input logic l, input logic r, input logic [AW-1:0] a,
                        input logic [WW-1:0] d, input logic [1:0] b);
        ld_n = l; rw = r; addr = a; wd = d; bws_n = b;
        @(negedge clk);
    endtask

    task automatic chk_out(input string tag, input int k, input logic eoe, input logic [WW-1:0] ed);
        logic [WW:0] exp_all;
        exp_all = {eoe, eoe ? ed : {WW{1'b0}}};
        checks++;
        if ({rd_oe, rd_data} !== exp_all) begin
            errors++;
            $display("FAIL %s op%0d: actual oe=%0b data=%05h expected oe=%0b data=%05h",
                     tag, k, rd_oe, rd_data, exp_all[WW], exp_all[WW-1:0]);
        end
    endtask

    function automatic logic [WW-1:0] merge(input logic [WW-1:0] old, input logic [WW-1:0] d,
                                            input logic [1:0] b);
        logic [WW-1:0] r;
        r = old;
        if (!b[0]) r[8:0]  = d[8:0];
        if (!b[1]) r[17:9] = d[17:9];
        return r;
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R8: actual run still busy, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) refm[i] = '0;
        for (int i = 0; i < NOPS; i++) begin exp_v[i] = 0; exp0[i] = '0; exp1[i] = '0; end

        repeat (3) @(negedge clk);
        chk_out("R1 reset", -1, 1'b0, '0);
        rst_n = 1'b1;

        // Table walk: cycle c issues op c, feeds the data of op c-1.
        for (int c = 0; c < NOPS + 2; c++) begin
            logic [49:0] op, pv;
            op = (c < NOPS) ? OPS[c] : '0;
            pv = (c >= 1 && c - 1 < NOPS) ? OPS[c-1] : '0;
            if (op[49:48] == 2'd1) begin
                exp_v[c] = 1;
                exp0[c]  = refm[{op[47:40], 1'b0}];
                exp1[c]  = refm[{op[47:40], 1'b1}];
            end else if (op[49:48] == 2'd2) begin
                refm[{op[47:40], 1'b0}] = merge(refm[{op[47:40], 1'b0}], op[39:22], op[3:2]);
                refm[{op[47:40], 1'b1}] = merge(refm[{op[47:40], 1'b1}], op[21:4], op[1:0]);
            end
            // positive slot; junk data with lanes enabled when no write is due
            if (pv[49:48] == 2'd2)
                slot(op[49:48] == 2'd0, op[49:48] == 2'd1, op[47:40], pv[39:22], pv[3:2]);
            else
                slot(op[49:48] == 2'd0, op[49:48] == 2'd1, op[47:40], 18'h2DB6D, 2'b00);
            if (c >= 2 && exp_v[c-2]) chk_out("R3 R6 R8 word1", c - 2, 1'b1, exp1[c-2]);
            else                      chk_out("R7 idle", c - 2, 1'b0, '0);
            // negative slot; a read strobe here must be ignored (R2)
            if (pv[49:48] == 2'd2) slot(1'b0, 1'b1, 8'h10, pv[21:4], pv[1:0]);
            else                   slot(1'b0, 1'b1, 8'h10, 18'h1B6DB, 2'b00);
            if (c >= 1 && c - 1 < NOPS && exp_v[c-1]) chk_out("R3 R6 word0", c - 1, 1'b1, exp0[c-1]);
            else                                      chk_out("R2 R7 idle", c - 1, 1'b0, '0);
        end

        // Reset in the middle of a read burst
        slot(1'b0, 1'b1, 8'h12, '0, 2'b11);
        slot(1'b1, 1'b1, 8'h00, '0, 2'b11);
        rst_n = 1'b0;
        #1;
        chk_out("R1 async reset", 100, 1'b0, '0);
        repeat (2) @(negedge clk);
        chk_out("R1 held reset", 101, 1'b0, '0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            slot(1'b1, 1'b1, 8'h00, '0, 2'b11);
            chk_out("R1 no leftover burst", 102, 1'b0, '0);
        end

        // Fresh read after reset: exact latency and fall of rd_oe
        slot(1'b0, 1'b1, 8'h12, '0, 2'b11);
        chk_out("R6 edge1 quiet", 103, 1'b0, '0);
        slot(1'b1, 1'b1, 8'h00, '0, 2'b11);
        chk_out("R6 edge2 quiet", 104, 1'b0, '0);
        slot(1'b1, 1'b1, 8'h00, '0, 2'b11);
        chk_out("R6 edge3 quiet", 105, 1'b0, '0);
        slot(1'b1, 1'b1, 8'h00, '0, 2'b11);
        chk_out("R6 word0 after reset", 106, 1'b1, refm[{8'h12, 1'b0}]);
        slot(1'b1, 1'b1, 8'h00, '0, 2'b11);
        chk_out("R6 word1 after reset", 107, 1'b1, refm[{8'h12, 1'b1}]);
        slot(1'b1, 1'b1, 8'h00, '0, 2'b11);
        chk_out("R7 fall after burst", 108, 1'b0, '0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule